// File: doc/BRIEF.md
# Port Link Speed and Activity Indicator

This block produces the two status indicators for one port of a copper/fiber media converter. The speed pin carries a three-state code: it is driven high while a 100 Mb/s signal is present on the port, driven low while a 10 Mb/s signal is present, and released when no signal of either rate is seen. Idle symbols count as a present signal, so the pin reflects link presence and not only traffic. Each pin is presented as an output-enable and a value, and the pad driver is outside the block.

The activity pin drives an active-low LED whose meaning depends on the speed state. With no speed detected, the LED is pulled low for as long as an auto-negotiation signal is being received. Once a speed is detected, it is pulled low on packet activity instead. Each single-cycle packet pulse is stretched using a coarse free-running tick, so the lit time lies between one and two tick periods and is not a fixed width. A fast-test bit selects a much longer tick period, and a test override replaces both pins with externally supplied values. All inputs are plain control and status signals with no flow control.

Top module: `port_led_ctrl`

## Requirements
- R1: During synchronous reset, and on the first clock edge after it, both output enables (`spd_oe`, `act_oe`) are low and both values are low.
- R2: The speed code `spd_state` is 2'b00 for no signal, 2'b01 for 10 Mb/s, 2'b10 for 100 Mb/s; 2'b11 is treated as no signal. One cycle after the code is sampled, `spd_oe`/`spd_val` are 1/1 for 100 Mb/s, 1/0 for 10 Mb/s and 0/0 for no signal.
- R3: With no speed detected, `act_oe` is 1 with `act_val` 0 one cycle after `aneg_present` is sampled high, and `act_oe` is 0 one cycle after it is sampled low. Packet pulses have no effect in this state.
- R4: With a speed detected, `aneg_present` has no effect on the activity pin, and a packet pulse drives `act_oe` high with `act_val` low, starting two cycles after the pulse is sampled.
- R5: In normal mode, a lone packet pulse keeps `act_oe` high for between NORM_TICK_CYC+1 and 2*NORM_TICK_CYC consecutive cycles.
- R6: With `fast_test` set, a lone packet pulse keeps `act_oe` high for between FAST_TICK_CYC+1 and 2*FAST_TICK_CYC consecutive cycles.
- R7: A packet pulse that arrives during an active stretch restarts the stretch, so two pulses NORM_TICK_CYC cycles apart give one unbroken low level of 2*NORM_TICK_CYC+1 to 3*NORM_TICK_CYC cycles.
- R8: When the speed code returns to no signal, any pending stretch is discarded at once; if a speed is detected again before a new packet, `act_oe` stays low.
- R9: While `test_en` is high, one cycle later both enables are 1 and `spd_val`/`act_val` equal `test_spd_val`/`test_act_val` as sampled, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| spd_state | input | 2 | Detected line speed code |
| aneg_present | input | 1 | Auto-negotiation signal being received |
| pkt_pulse | input | 1 | One-cycle pulse per detected packet |
| fast_test | input | 1 | Selects the long stretch tick period |
| test_en | input | 1 | Replace both pins with test values |
| test_spd_val | input | 1 | Test value for the speed pin |
| test_act_val | input | 1 | Test value for the activity pin |
| spd_oe | output | 1 | Speed pin drive enable |
| spd_val | output | 1 | Speed pin level when driven |
| act_oe | output | 1 | Activity pin drive enable |
| act_val | output | 1 | Activity pin level when driven |

## Verification
The bound checker watches, on every cycle, the one-cycle mapping from the speed code to the speed pin, the switch of the activity pin between the auto-negotiation and packet meanings, the start of a stretch two cycles after a pulse, the test override, and the released state after reset. The width of the stretch depends on where the free-running tick falls, so the range limits in normal and fast mode, the merging of back-to-back pulses and the discarding of a stretch when the link drops are shown only by the bench's scenarios. Those scenarios measure the lit time in cycles with shortened tick periods.

// File: rtl/port_led_pkg.sv
package port_led_pkg;
  typedef enum logic [1:0] {
    SPD_NONE = 2'b00,
    SPD_10M  = 2'b01,
    SPD_100M = 2'b10,
    SPD_RSVD = 2'b11
  } spd_code_e;

  typedef struct packed {
    logic oe;
    logic val;
  } pin_drv_t;

  localparam pin_drv_t PIN_RELEASED = '{oe: 1'b0, val: 1'b0};

  function automatic logic spd_is_present(input logic [1:0] code);
    return (code == SPD_10M) || (code == SPD_100M);
  endfunction
endpackage

// File: rtl/led_tick_gen.sv
module led_tick_gen #(
  parameter int unsigned NORM_TICK_CYC = 168750,
  parameter int unsigned FAST_TICK_CYC = 20500000
) (
  input  logic clk,
  input  logic rst,
  input  logic fast_sel,
  output logic tick
);
  localparam int unsigned MAX_CYC = (FAST_TICK_CYC > NORM_TICK_CYC) ? FAST_TICK_CYC : NORM_TICK_CYC;
  localparam int unsigned CW      = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
  localparam logic [CW-1:0] NORM_LAST = CW'(NORM_TICK_CYC - 1);
  localparam logic [CW-1:0] FAST_LAST = CW'(FAST_TICK_CYC - 1);

  logic [CW-1:0] phase_q;
  logic [CW-1:0] last_cnt;

  assign last_cnt = fast_sel ? FAST_LAST : NORM_LAST;
  // a mode change that leaves the phase beyond the new limit wraps at once
  assign tick = (phase_q >= last_cnt);

  always_ff @(posedge clk) begin
    if (rst)       phase_q <= '0;
    else if (tick) phase_q <= '0;
    else           phase_q <= phase_q + 1'b1;
  end
endmodule

// File: rtl/led_pulse_stretch.sv
module led_pulse_stretch #(
  parameter int unsigned HOLD_TICKS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic flush,
  input  logic load,
  input  logic tick,
  output logic active
);
  localparam int unsigned HW = $clog2(HOLD_TICKS + 1);
  localparam logic [HW-1:0] HOLD_INIT = HW'(HOLD_TICKS);

  logic [HW-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (rst || flush)                    remain_q <= '0;
    else if (load)                       remain_q <= HOLD_INIT;
    else if (tick && remain_q != '0)     remain_q <= remain_q - 1'b1;
  end

  assign active = (remain_q != '0);
endmodule

// File: rtl/port_led_ctrl.sv
module port_led_ctrl
  import port_led_pkg::*;
#(
  parameter int unsigned NORM_TICK_CYC = 168750,
  parameter int unsigned FAST_TICK_CYC = 20500000,
  parameter int unsigned HOLD_TICKS    = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] spd_state,
  input  logic       aneg_present,
  input  logic       pkt_pulse,
  input  logic       fast_test,
  input  logic       test_en,
  input  logic       test_spd_val,
  input  logic       test_act_val,
  output logic       spd_oe,
  output logic       spd_val,
  output logic       act_oe,
  output logic       act_val
);
  logic     tick;
  logic     link_up;
  logic     stretch_on;
  pin_drv_t spd_nxt, act_nxt;
  pin_drv_t spd_q, act_q;

  assign link_up = spd_is_present(spd_state);

  led_tick_gen #(
    .NORM_TICK_CYC(NORM_TICK_CYC),
    .FAST_TICK_CYC(FAST_TICK_CYC)
  ) u_tick (
    .clk     (clk),
    .rst     (rst),
    .fast_sel(fast_test),
    .tick    (tick)
  );

  led_pulse_stretch #(
    .HOLD_TICKS(HOLD_TICKS)
  ) u_stretch (
    .clk   (clk),
    .rst   (rst),
    .flush (!link_up),
    .load  (pkt_pulse),
    .tick  (tick),
    .active(stretch_on)
  );

  always_comb begin
    if (test_en) begin
      spd_nxt = '{oe: 1'b1, val: test_spd_val};
      act_nxt = '{oe: 1'b1, val: test_act_val};
    end else begin
      spd_nxt = '{oe: link_up, val: (spd_state == SPD_100M)};
      // LED is active low: only ever driven to 0 in normal operation
      act_nxt = '{oe: (link_up ? stretch_on : aneg_present), val: 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      spd_q <= PIN_RELEASED;
      act_q <= PIN_RELEASED;
    end else begin
      spd_q <= spd_nxt;
      act_q <= act_nxt;
    end
  end

  assign spd_oe  = spd_q.oe;
  assign spd_val = spd_q.val;
  assign act_oe  = act_q.oe;
  assign act_val = act_q.val;
endmodule

// File: rtl/port_led_ctrl_chk.sv
module port_led_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] spd_state,
  input logic       aneg_present,
  input logic       pkt_pulse,
  input logic       fast_test,
  input logic       test_en,
  input logic       test_spd_val,
  input logic       test_act_val,
  input logic       spd_oe,
  input logic       spd_val,
  input logic       act_oe,
  input logic       act_val
);
  logic up;
  assign up = (spd_state == 2'b01) || (spd_state == 2'b10);

  // R1
  reset_release_chk: assert property (@(posedge clk)
    rst |=> (!spd_oe && !act_oe && !spd_val && !act_val));

  // R2
  spd_map_chk: assert property (@(posedge clk) disable iff (rst)
    !test_en |=> (spd_oe == $past(up)) && (spd_val == ($past(spd_state) == 2'b10)));

  // R3
  aneg_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (!test_en && !up) |=> (act_oe == $past(aneg_present)) && !act_val);

  // R4
  pkt_start_chk: assert property (@(posedge clk) disable iff (rst)
    (!test_en && up && pkt_pulse) ##1 (!test_en && up) |=> (act_oe && !act_val));

  // R4
  low_only_chk: assert property (@(posedge clk) disable iff (rst)
    (!test_en && act_oe) |=> (!act_oe || !act_val || $past(test_en)));

  // R9
  test_override_chk: assert property (@(posedge clk) disable iff (rst)
    test_en |=> (spd_oe && act_oe && spd_val == $past(test_spd_val) && act_val == $past(test_act_val)));
endmodule

bind port_led_ctrl port_led_ctrl_chk u_chk (.*);

// File: tb/tb_port_led_ctrl.sv
`timescale 1ns/1ps
module tb_port_led_ctrl;
  localparam int unsigned NP = 8;
  localparam int unsigned FP = 32;

  logic clk = 1'b0;
  logic rst;
  logic [1:0] spd_state;
  logic aneg_present, pkt_pulse, fast_test, test_en, test_spd_val, test_act_val;
  logic spd_oe, spd_val, act_oe, act_val;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  port_led_ctrl #(.NORM_TICK_CYC(NP), .FAST_TICK_CYC(FP), .HOLD_TICKS(2)) dut (
    .clk(clk), .rst(rst), .spd_state(spd_state), .aneg_present(aneg_present),
    .pkt_pulse(pkt_pulse), .fast_test(fast_test), .test_en(test_en),
    .test_spd_val(test_spd_val), .test_act_val(test_act_val),
    .spd_oe(spd_oe), .spd_val(spd_val), .act_oe(act_oe), .act_val(act_val)
  );

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_range(input string req, input int act, input int lo, input int hi);
    n_run++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  // Counts the lit run after a pulse at loop index 0 and optionally a second one at index gap.
  task automatic measure(input int gap, output int len, output int lowbad);
    len = 0;
    lowbad = 0;
    for (int i = 0; i < 400; i++) begin
      pkt_pulse = (i == 0) || (gap > 0 && i == gap);
      step();
      if (act_oe) begin
        len++;
        if (act_val) lowbad++;
      end else if (len > 0) begin
        break;
      end
    end
    pkt_pulse = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; spd_state = 2'b10; aneg_present = 1'b1; pkt_pulse = 1'b0;
    fast_test = 1'b0; test_en = 1'b0; test_spd_val = 1'b1; test_act_val = 1'b1;
    step(3);
    // R1
    check("R1 spd_oe in reset", spd_oe, 0);
    check("R1 act_oe in reset", act_oe, 0);
    rst = 1'b0;
    spd_state = 2'b00; aneg_present = 1'b0;
    step(2);
  endtask

  task automatic t_speed_codes();
    spd_state = 2'b10; step();
    check("R2 100M oe", spd_oe, 1); check("R2 100M val", spd_val, 1);
    spd_state = 2'b01; step();
    check("R2 10M oe", spd_oe, 1); check("R2 10M val", spd_val, 0);
    spd_state = 2'b00; step();
    check("R2 none oe", spd_oe, 0);
    spd_state = 2'b11; step();
    check("R2 code 3 oe", spd_oe, 0);
    spd_state = 2'b00; step();
  endtask

  task automatic t_aneg();
    aneg_present = 1'b1; step();
    check("R3 aneg oe", act_oe, 1); check("R3 aneg val", act_val, 0);
    aneg_present = 1'b0; pkt_pulse = 1'b1; step();
    pkt_pulse = 1'b0;
    check("R3 aneg drop", act_oe, 0);
    step(2);
    check("R3 pulse ignored without link", act_oe, 0);
  endtask

  task automatic t_link_ignores_aneg();
    spd_state = 2'b01; aneg_present = 1'b1;
    step(3 * NP);
    check("R4 aneg ignored with link", act_oe, 0);
    aneg_present = 1'b0;
  endtask

  task automatic t_pkt_start();
    spd_state = 2'b10; step(3);
    pkt_pulse = 1'b1; step(); pkt_pulse = 1'b0;
    check("R4 one cycle after pulse", act_oe, 0);
    step();
    check("R4 lit two cycles after pulse", act_oe, 1);
    check("R4 lit level low", act_val, 0);
    step(3 * NP);
  endtask

  task automatic t_width(input bit fast, input int p, input string req);
    int len, bad;
    fast_test = fast; spd_state = 2'b10;
    step(2 * p + 3);
    for (int k = 0; k < 3; k++) begin
      measure(0, len, bad);
      check_range(req, len, p + 1, 2 * p);
      check({req, " level"}, bad, 0);
      step(k + 3);
    end
    fast_test = 1'b0;
    step(2 * FP + 2);
  endtask

  task automatic t_retrigger();
    int len, bad;
    spd_state = 2'b10; step(2 * NP + 2);
    measure(NP, len, bad);
    // R7
    check_range("R7 merged low level", len, 2 * NP + 1, 3 * NP);
    step(2);
  endtask

  task automatic t_flush();
    spd_state = 2'b10; step(2);
    pkt_pulse = 1'b1; step(); pkt_pulse = 1'b0;
    step(2);
    check("R8 lit before drop", act_oe, 1);
    spd_state = 2'b00; aneg_present = 1'b0; step();
    check("R8 released on drop", act_oe, 0);
    spd_state = 2'b10; step(); step();
    check("R8 stretch discarded", act_oe, 0);
    spd_state = 2'b00; aneg_present = 1'b1;
    pkt_pulse = 1'b1; step(); pkt_pulse = 1'b0;
    check("R8 aneg shown after drop", act_oe, 1);
    aneg_present = 1'b0; step();
  endtask

  task automatic t_test_mode();
    spd_state = 2'b00; aneg_present = 1'b0;
    test_en = 1'b1; test_spd_val = 1'b1; test_act_val = 1'b0; step();
    check("R9 spd oe", spd_oe, 1); check("R9 spd val", spd_val, 1);
    check("R9 act oe", act_oe, 1); check("R9 act val", act_val, 0);
    test_spd_val = 1'b0; test_act_val = 1'b1; spd_state = 2'b10; step();
    check("R9 spd val over link", spd_val, 0);
    check("R9 act val high", act_val, 1);
    test_en = 1'b0; spd_state = 2'b00; step();
    check("R9 exit releases", act_oe, 0);
  endtask

  initial begin
    t_reset();
    t_speed_codes();
    t_aneg();
    t_link_ignores_aneg();
    t_pkt_start();
    t_width(1'b0, NP, "R5 normal width");
    t_width(1'b1, FP, "R6 fast width");
    t_retrigger();
    t_flush();
    t_test_mode();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule